// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block is a synchronous reset supervisor. It takes a digital flag from a supply comparator that reads high while the supply is above its threshold. It also takes the sensed levels of two bidirectional reset pads and a watchdog kick input. It drives the reset pads as open-drain enables. At power-up it holds reset until a fixed timeout has run after the supply becomes good. Short dips of the supply flag are filtered out, while a sustained drop asserts reset at once. A level held on either reset pad by outside logic keeps the system in reset, and the timeout restarts when the pad is let go. The watchdog restarts the timeout when the kick input has been quiet for too long, and it stays cleared for as long as reset is asserted. A separate write-lock output blocks writes to an attached memory while the supply is low.

All times are parameters counted in clock cycles. The two reset pads are modelled as one pad that is active high and one that is active low. Each output enable means "pull this pad to its active level". When an enable is off, the pad floats to its inactive level through an external pull device. The comparator, the threshold trimming and the analog side are outside the block. The synchronous `rst` input stands in for the condition where the supply is too low for the logic to work.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both pad enables, `rst_active_o` and `write_lock_o` are 1.
- R2: After the supply flag rises, its synchronised value is seen 3 edges later. Reset is then held for exactly POR_CYC more cycles, so `rst_active_o` falls POR_CYC+3 edges after the first high sample. A release is always preceded by at least POR_CYC cycles of reset.
- R3: A low pulse on `supply_ok_i` lasting at most GLITCH_CYC-1 consecutive samples does not assert reset.
- R4: When `supply_ok_i` is sampled low GLITCH_CYC times in a row, `rst_active_o` and both enables become 1 on the GLITCH_CYC+2-th edge after the first low sample.
- R5: Pad enable encoding: `rst_hi_oe_o`=1 pulls the active-high pad high, and `rst_lo_oe_o`=1 pulls the active-low pad low. Both enables are 0 whenever `rst_active_o` is 0.
- R6: A high level held on `rst_hi_pad_i` while the block runs asserts reset and drives only `rst_lo_oe_o`. Once the pad is released, reset lasts POR_CYC cycles past the edge at which the synchronised release is seen.
- R7: A low level held on `rst_lo_pad_n_i` while the block runs asserts reset and drives only `rst_hi_oe_o`. Release then times out as in R6.
- R8: When no kick edge is seen for WDOG_CYC cycles in the running state, the block enters the reset timeout. After a kick at the edge before e0, reset asserts on edge e0+WDOG_CYC+2.
- R9: Both rising and falling edges of `wdog_kick_i` restart the watchdog count.
- R10: The watchdog count is held at zero while reset is asserted and during the settle window. Kicks made during reset have no effect, and a full WDOG_CYC window runs from entry to the running state.
- R11: `write_lock_o` equals the inverse of `supply_ok_i` delayed by 3 edges, with no glitch filtering.
- R12: For SETTLE_CYC cycles after reset is released, the pad inputs are ignored, so the block's own released drive cannot retrigger it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_ok_i | input | 1 | Comparator flag, 1 = supply above threshold (asynchronous) |
| rst_hi_pad_i | input | 1 | Sensed level of the active-high reset pad |
| rst_lo_pad_n_i | input | 1 | Sensed level of the active-low reset pad |
| wdog_kick_i | input | 1 | Watchdog kick, any edge counts |
| rst_hi_oe_o | output | 1 | 1 = pull the active-high pad high |
| rst_lo_oe_o | output | 1 | 1 = pull the active-low pad low |
| rst_active_o | output | 1 | Reset currently asserted by the supervisor |
| write_lock_o | output | 1 | 1 = memory writes blocked |

## Verification
On every cycle the assertions check four things: that released reset never leaves a pad driven, that a sustained supply drop always ends in reset, that the write lock tracks the delayed supply flag, and that no release comes earlier than the power-up timeout. Other behaviours depend on event order and only the bench scenarios can show them. These are glitch rejection at its exact width, which pad is driven while the other is held outside, the timeout restarting from release of an outside reset, kick edges of both polarities, the watchdog being ignored while in reset, and the settle window after release. The bench follows each of these against its reference model cycle by cycle.

// File: rtl/supply_sup_pkg.sv
package supply_sup_pkg;

  typedef enum logic [2:0] {
    SUP_DOWN    = 3'd0,
    SUP_TIMEOUT = 3'd1,
    SUP_SETTLE  = 3'd2,
    SUP_RUN     = 3'd3,
    SUP_EXT     = 3'd4
  } sup_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int          WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= RST_VAL[b];
        stage2 <= RST_VAL[b];
      end else begin
        stage1 <= async_i[b];
        stage2 <= stage1;
      end
    end
    assign sync_o[b] = stage2;
  end

endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
  parameter int GLITCH_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic good_o
);

  localparam int LW = $clog2(GLITCH_CYC + 1);

  logic [LW-1:0] low_run;
  logic          good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      good_q  <= 1'b0;
    end else if (level_i) begin
      low_run <= '0;
      good_q  <= 1'b1;
    end else if (low_run == LW'(GLITCH_CYC - 1)) begin
      good_q  <= 1'b0;
    end else begin
      low_run <= low_run + 1'b1;
    end
  end

  assign good_o = good_q;

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int WDOG_CYC = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);

  localparam int WW = $clog2(WDOG_CYC + 1);

  logic [WW-1:0] tick;
  logic          kick_prev;
  logic          kick_edge;

  assign kick_edge = kick_i ^ kick_prev;
  assign expire_o  = run_i && !kick_edge && (tick == WW'(WDOG_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      kick_prev <= 1'b0;
      tick      <= '0;
    end else begin
      kick_prev <= kick_i;
      if (!run_i || kick_edge || expire_o) tick <= '0;
      else                                 tick <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supply_sup_pkg::*;
#(
  parameter int GLITCH_CYC = 13,
  parameter int POR_CYC    = 25_000_000,
  parameter int WDOG_CYC   = 200_000_000,
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic rst_hi_pad_i,
  input  logic rst_lo_pad_n_i,
  input  logic wdog_kick_i,
  output logic rst_hi_oe_o,
  output logic rst_lo_oe_o,
  output logic rst_active_o,
  output logic write_lock_o
);

  localparam int MAXC  = max_int(POR_CYC, SETTLE_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [3:0] SYNC_RST = 4'b0100;

  logic [3:0] raw_in, syn;
  logic       s_supply, s_hi, s_lo_n, s_kick;
  logic       supply_good, wd_expire;

  sup_state_e       state, nxt_state;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             src_hi, nxt_src;
  logic             hi_oe_d, lo_oe_d, act_d;
  logic             hi_oe_q, lo_oe_q, act_q, lock_q;

  assign raw_in = {wdog_kick_i, rst_lo_pad_n_i, rst_hi_pad_i, supply_ok_i};

  sup_sync #(.WIDTH(4), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw_in), .sync_o(syn)
  );

  assign s_supply = syn[0];
  assign s_hi     = syn[1];
  assign s_lo_n   = syn[2];
  assign s_kick   = syn[3];

  sup_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst(rst), .level_i(s_supply), .good_o(supply_good)
  );

  sup_watchdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk(clk), .rst(rst), .run_i(state == SUP_RUN),
    .kick_i(s_kick), .expire_o(wd_expire)
  );

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    nxt_src   = src_hi;
    if (!supply_good) begin
      nxt_state = SUP_DOWN;
      nxt_cnt   = '0;
    end else begin
      unique case (state)
        SUP_DOWN: begin
          nxt_state = SUP_TIMEOUT;
          nxt_cnt   = '0;
        end
        SUP_TIMEOUT: begin
          if (cnt == CNT_W'(POR_CYC - 1)) begin
            nxt_state = SUP_SETTLE;
            nxt_cnt   = '0;
          end else begin
            nxt_cnt = cnt + 1'b1;
          end
        end
        SUP_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            nxt_state = SUP_RUN;
            nxt_cnt   = '0;
          end else begin
            nxt_cnt = cnt + 1'b1;
          end
        end
        SUP_RUN: begin
          nxt_cnt = '0;
          if (s_hi || !s_lo_n) begin
            nxt_state = SUP_EXT;
            nxt_src   = s_hi;
          end else if (wd_expire) begin
            nxt_state = SUP_TIMEOUT;
          end
        end
        SUP_EXT: begin
          nxt_cnt = '0;
          if (!(src_hi ? s_hi : !s_lo_n)) nxt_state = SUP_TIMEOUT;
        end
        default: begin
          nxt_state = SUP_DOWN;
          nxt_cnt   = '0;
        end
      endcase
    end
  end

  always_comb begin
    act_d   = (nxt_state == SUP_DOWN) || (nxt_state == SUP_TIMEOUT) ||
              (nxt_state == SUP_EXT);
    hi_oe_d = (nxt_state == SUP_DOWN) || (nxt_state == SUP_TIMEOUT) ||
              ((nxt_state == SUP_EXT) && !nxt_src);
    lo_oe_d = (nxt_state == SUP_DOWN) || (nxt_state == SUP_TIMEOUT) ||
              ((nxt_state == SUP_EXT) && nxt_src);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SUP_DOWN;
      cnt     <= '0;
      src_hi  <= 1'b1;
      hi_oe_q <= 1'b1;
      lo_oe_q <= 1'b1;
      act_q   <= 1'b1;
      lock_q  <= 1'b1;
    end else begin
      state   <= nxt_state;
      cnt     <= nxt_cnt;
      src_hi  <= nxt_src;
      hi_oe_q <= hi_oe_d;
      lo_oe_q <= lo_oe_d;
      act_q   <= act_d;
      lock_q  <= !s_supply;
    end
  end

  assign rst_hi_oe_o  = hi_oe_q;
  assign rst_lo_oe_o  = lo_oe_q;
  assign rst_active_o = act_q;
  assign write_lock_o = lock_q;

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int GLITCH_CYC = 13,
  parameter int POR_CYC    = 25_000_000,
  parameter int WDOG_CYC   = 200_000_000,
  parameter int SETTLE_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic supply_ok_i,
  input logic rst_hi_pad_i,
  input logic rst_lo_pad_n_i,
  input logic wdog_kick_i,
  input logic rst_hi_oe_o,
  input logic rst_lo_oe_o,
  input logic rst_active_o,
  input logic write_lock_o
);

  logic [2:0]  since_rst;
  logic [31:0] low_run;
  logic [31:0] act_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      low_run   <= '0;
      act_len   <= '0;
    end else begin
      if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
      if (supply_ok_i) low_run <= '0;
      else if (low_run < 32'(GLITCH_CYC + 3)) low_run <= low_run + 1'b1;
      if (!rst_active_o) act_len <= '0;
      else if (act_len != 32'hFFFF_FFFF) act_len <= act_len + 1'b1;
    end
  end

  // R5
  released_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_active_o |-> (!rst_hi_oe_o && !rst_lo_oe_o));

  // R4
  low_supply_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (low_run >= 32'(GLITCH_CYC + 3)) |-> rst_active_o);

  // R11
  lock_follows_supply_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (write_lock_o == !$past(supply_ok_i, 3)));

  // R2
  por_hold_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_active_o) |-> (act_len >= 32'(POR_CYC)));

endmodule

bind supply_supervisor sup_checker #(
  .GLITCH_CYC(GLITCH_CYC), .POR_CYC(POR_CYC),
  .WDOG_CYC(WDOG_CYC), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i),
  .rst_hi_pad_i(rst_hi_pad_i), .rst_lo_pad_n_i(rst_lo_pad_n_i),
  .wdog_kick_i(wdog_kick_i), .rst_hi_oe_o(rst_hi_oe_o),
  .rst_lo_oe_o(rst_lo_oe_o), .rst_active_o(rst_active_o),
  .write_lock_o(write_lock_o)
);

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;

  localparam int G  = 5;
  localparam int P  = 40;
  localparam int W  = 100;
  localparam int SE = 3;

  localparam int M_DOWN = 0, M_TMO = 1, M_SET = 2, M_RUN = 3, M_EXT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply = 1'b0;
  logic ext_hi = 1'b0;
  logic ext_lo = 1'b0;
  logic kick = 1'b0;
  logic auto_kick = 1'b0;
  logic hi_oe, lo_oe, act, lock;
  logic hi_pad, lo_pad_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  assign hi_pad   = hi_oe | ext_hi;
  assign lo_pad_n = !(lo_oe | ext_lo);

  supply_supervisor #(.GLITCH_CYC(G), .POR_CYC(P), .WDOG_CYC(W), .SETTLE_CYC(SE)) uut (
    .clk(clk), .rst(rst), .supply_ok_i(supply), .rst_hi_pad_i(hi_pad),
    .rst_lo_pad_n_i(lo_pad_n), .wdog_kick_i(kick), .rst_hi_oe_o(hi_oe),
    .rst_lo_oe_o(lo_oe), .rst_active_o(act), .write_lock_o(lock)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Behavioural reference model, stepped once per cycle at the falling edge
  int sq[$], hq[$], lq[$], kq[$];
  int m_state = M_DOWN, m_cnt = 0, m_wd = 0, m_src = 1, m_good = 0, m_low = 0, m_kprev = 0;
  int e_hi = 1, e_lo = 1, e_act = 1, e_lock = 1;

  always @(negedge clk) begin
    int sv, hv, lv, kv, pad_h, pad_l, g_old, edge_k, expire, ns, nc, nsrc;
    if (rst) begin
      sq = '{0, 0}; hq = '{0, 0}; lq = '{1, 1}; kq = '{0, 0};
      m_state = M_DOWN; m_cnt = 0; m_wd = 0; m_src = 1; m_good = 0; m_low = 0; m_kprev = 0;
      e_hi = 1; e_lo = 1; e_act = 1; e_lock = 1;
    end else begin
      pad_h = (e_hi != 0 || ext_hi) ? 1 : 0;
      pad_l = (e_lo != 0 || ext_lo) ? 0 : 1;
      sv = sq.pop_front(); sq.push_back(int'(supply));
      hv = hq.pop_front(); hq.push_back(pad_h);
      lv = lq.pop_front(); lq.push_back(pad_l);
      kv = kq.pop_front(); kq.push_back(int'(kick));
      edge_k = (kv != m_kprev) ? 1 : 0;
      m_kprev = kv;
      g_old = m_good;
      if (sv != 0) begin m_good = 1; m_low = 0; end
      else if (m_low == G - 1) m_good = 0;
      else m_low++;
      e_lock = (sv != 0) ? 0 : 1;
      expire = (m_state == M_RUN && edge_k == 0 && m_wd == W - 1) ? 1 : 0;
      m_wd = (m_state != M_RUN || edge_k != 0 || expire != 0) ? 0 : m_wd + 1;
      ns = m_state; nc = m_cnt; nsrc = m_src;
      if (g_old == 0) begin ns = M_DOWN; nc = 0; end
      else begin
        case (m_state)
          M_DOWN: begin ns = M_TMO; nc = 0; end
          M_TMO: if (m_cnt == P - 1) begin ns = M_SET; nc = 0; end else nc = m_cnt + 1;
          M_SET: if (m_cnt == SE - 1) begin ns = M_RUN; nc = 0; end else nc = m_cnt + 1;
          M_RUN: begin
            nc = 0;
            if (hv != 0 || lv == 0) begin ns = M_EXT; nsrc = hv; end
            else if (expire != 0) ns = M_TMO;
          end
          default: begin
            nc = 0;
            if (!((m_src != 0) ? (hv != 0) : (lv == 0))) ns = M_TMO;
          end
        endcase
      end
      m_state = ns; m_cnt = nc; m_src = nsrc;
      e_act = (ns == M_DOWN || ns == M_TMO || ns == M_EXT) ? 1 : 0;
      e_hi  = (ns == M_DOWN || ns == M_TMO || (ns == M_EXT && nsrc == 0)) ? 1 : 0;
      e_lo  = (ns == M_DOWN || ns == M_TMO || (ns == M_EXT && nsrc != 0)) ? 1 : 0;
    end
    check(int'(act) == e_act, {cur_req, " model rst_active"}, int'(act), e_act);
    check(int'(hi_oe) == e_hi, {cur_req, " model hi_oe"}, int'(hi_oe), e_hi);
    check(int'(lo_oe) == e_lo, {cur_req, " model lo_oe"}, int'(lo_oe), e_lo);
    check(int'(lock) == e_lock, {cur_req, " model write_lock"}, int'(lock), e_lock);
  end

  // Background kicker
  initial begin
    int n = 0;
    forever begin
      @(negedge clk); #1;
      if (auto_kick) begin
        n++;
        if (n >= 30) begin kick = ~kick; n = 0; end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_point();
    @(negedge clk); #1;
  endtask

  initial begin
    // R1 reset state
    cyc(5);
    check(act && hi_oe && lo_oe && lock, "R1 reset outputs", int'({act, hi_oe, lo_oe, lock}), 15);
    drive_point(); rst = 1'b0;
    cyc(1);
    check(act && hi_oe && lo_oe && lock, "R1 first cycle after reset", int'({act, hi_oe, lo_oe, lock}), 15);
    cyc(6);

    // R2 power-up hold
    cur_req = "R2";
    drive_point(); supply = 1'b1;
    cyc(P + 3);
    check(act == 1'b1, "R2 still held", int'(act), 1);
    cyc(1);
    check(act == 1'b0, "R2 released", int'(act), 0);
    auto_kick = 1'b1;
    // R12 settle window
    cur_req = "R12";
    cyc(SE + 4);
    check(act == 1'b0, "R12 no retrigger after release", int'(act), 0);

    // R3 glitch rejection, R11 unfiltered lock
    cur_req = "R3";
    drive_point(); supply = 1'b0;
    cyc(3);
    check(lock == 1'b1, "R11 lock on dip", int'(lock), 1);
    cyc(G - 4);
    #1 supply = 1'b1;
    cyc(12);
    check(act == 1'b0, "R3 glitch ignored", int'(act), 0);
    check(lock == 1'b0, "R11 lock cleared", int'(lock), 0);

    // R4 power-down
    cur_req = "R4";
    drive_point(); supply = 1'b0;
    cyc(G + 2);
    check(act == 1'b0, "R4 before filter expiry", int'(act), 0);
    cyc(1);
    check(act && hi_oe && lo_oe, "R4 reset on drop", int'({act, hi_oe, lo_oe}), 7);
    cyc(10);
    drive_point(); supply = 1'b1;
    cur_req = "R2";
    cyc(P + 4);
    check(act == 1'b0, "R2 release after recovery", int'(act), 0);
    cyc(SE + 5);

    // R6 external high pad
    cur_req = "R6";
    drive_point(); ext_hi = 1'b1;
    cyc(6);
    check(act && lo_oe && !hi_oe, "R6 held, other pad driven", int'({act, hi_oe, lo_oe}), 5);
    cyc(14);
    drive_point(); ext_hi = 1'b0;
    cyc(P + 2);
    check(act == 1'b1, "R6 timeout from release", int'(act), 1);
    cyc(1);
    check(act == 1'b0, "R6 released", int'(act), 0);
    cyc(SE + 5);

    // R7 external low pad, R10 watchdog cleared during reset
    cur_req = "R7";
    auto_kick = 1'b0;
    drive_point(); ext_lo = 1'b1;
    cyc(6);
    check(act && hi_oe && !lo_oe, "R7 held, other pad driven", int'({act, hi_oe, lo_oe}), 6);
    for (int i = 0; i < 4; i++) begin drive_point(); kick = ~kick; cyc(2); end
    drive_point(); ext_lo = 1'b0;
    cyc(P + 3);
    check(act == 1'b0, "R7 released after timeout", int'(act), 0);
    cur_req = "R10";
    cyc(SE + W - 1);
    check(act == 1'b0, "R10 full window after release", int'(act), 0);
    cyc(1);
    check(act == 1'b1, "R10 expiry after full window", int'(act), 1);
    cur_req = "R8";
    cyc(P + SE + 4);
    auto_kick = 1'b1;
    cur_req = "R9";
    cyc(3 * W);
    check(act == 1'b0, "R9 periodic kicks keep running", int'(act), 0);

    // R8 watchdog expiry timing
    cur_req = "R8";
    @(negedge clk); auto_kick = 1'b0;
    drive_point(); kick = ~kick;
    cyc(W + 2);
    check(act == 1'b0, "R8 before expiry", int'(act), 0);
    cyc(1);
    check(act && hi_oe && lo_oe, "R8 expiry resets", int'({act, hi_oe, lo_oe}), 7);
    cyc(P + SE + 4);

    // R9 single falling edge restarts the count
    cur_req = "R9";
    drive_point(); kick = 1'b1;
    cyc(W - 20);
    drive_point(); kick = 1'b0;
    cyc(W - 10);
    check(act == 1'b0, "R9 falling edge cleared count", int'(act), 0);
    cyc(20);
    check(act == 1'b1, "R9 expiry after falling kick", int'(act), 1);
    cur_req = "R5";
    cyc(P + SE + 4);
    check(!act && !hi_oe && !lo_oe, "R5 enables off when released", int'({act, hi_oe, lo_oe}), 0);

    cyc(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule